// File: doc/BRIEF.md
# Trace Message Queue with Overrun Recovery

This block collects trace messages from four producers (watchpoint, ownership, branch and data) and holds them in one small first-in first-out store. A downstream consumer takes them out through a valid/ready stream. The block treats each message body as an opaque payload and tags it with a kind code. At most one message enters per cycle. When several producers offer in the same cycle, a fixed priority picks the one that is kept.

When the store is full and a message arrives, the block enters an overrun state. In this state it turns away every offered message until the consumer has removed all stored entries, even if space opens up sooner. While it refuses messages, it records a mask of the message kinds it dropped. When the store becomes empty, the block writes one error record that carries that mask. In the same step it raises a one-cycle sync request, which tells the branch producer that its next message must be a synchronization message.

Top module: `trq_top`

## Requirements
- R1: During and right after synchronous reset, out_valid and sync_req are 0.
- R2: When several producers offer in one cycle, only the message of highest priority is stored, with watchpoint over ownership over branch over data. The other offers in that cycle are discarded.
- R3: Stored messages leave in arrival order. Each carries its payload unchanged and a kind code: 0 watchpoint, 1 ownership, 2 branch, 3 data. An entry is removed at a clock edge where out_valid and out_ready are both 1.
- R4: The store holds DEPTH entries and accepts DEPTH messages with no consumer activity. At full, a removal in the same cycle does not let an offered message in.
- R5: A message offered while the store is full is discarded and starts an overrun. From then on, every offered message is discarded until the store is empty, even when entries are free.
- R6: The cycle after the store is seen empty during an overrun, an error record is stored with kind code 4. Its payload bits [3:0] hold the mask of kinds dropped since the overrun began, with bit 0 watchpoint, bit 1 ownership, bit 2 branch and bit 3 data. All higher payload bits are 0.
- R7: In the cycle the error record is written, the error record takes precedence: offers in that cycle are discarded, and their kinds are included in that record's mask.
- R8: sync_req is high for exactly one cycle, in the cycle right after the error record is written. In that cycle the error record is at the head of the output.
- R9: The dropped-kind mask clears when the error record is written, so a later overrun reports only its own dropped kinds.
- R10: A message accepted at a clock edge into an empty store is presented with out_valid high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_valid | input | 1 | Watchpoint message offered |
| wp_data | input | PAYLOAD_W | Watchpoint payload |
| own_valid | input | 1 | Ownership message offered |
| own_data | input | PAYLOAD_W | Ownership payload |
| br_valid | input | 1 | Branch message offered |
| br_data | input | PAYLOAD_W | Branch payload |
| dt_valid | input | 1 | Data message offered |
| dt_data | input | PAYLOAD_W | Data payload |
| out_valid | output | 1 | Head entry available |
| out_ready | input | 1 | Consumer takes the head entry |
| out_kind | output | 3 | Kind code of the head entry (4 = error record) |
| out_data | output | PAYLOAD_W | Payload of the head entry |
| sync_req | output | 1 | One-cycle pulse: next branch message must synchronize |

## Verification
Every result is due one edge after its stimulus. An offer or removal driven before an edge shows at out_valid, out_kind and out_data right after that edge. The error record and the sync_req pulse appear one edge after the edge at which the model sees an empty store while in overrun. The bench drives inputs on the falling edge and updates its arithmetic model of the store, the overrun flag and the mask from the state before the next rising edge. It compares outputs at the following falling edge, so each check samples in exactly the cycle its result is due.

// File: rtl/trq_pkg.sv
package trq_pkg;
  localparam int NUM_SRC = 4;
  localparam int KIND_W  = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_WP   = 3'd0,
    KIND_OWN  = 3'd1,
    KIND_BR   = 3'd2,
    KIND_DATA = 3'd3,
    KIND_ERR  = 3'd4
  } trq_kind_e;
endpackage

// File: rtl/trq_arbiter.sv
module trq_arbiter
  import trq_pkg::*;
#(
  parameter int PAYLOAD_W = 16
) (
  input  logic [NUM_SRC-1:0]           req,
  input  logic [NUM_SRC*PAYLOAD_W-1:0] req_data,
  output logic                         grant_valid,
  output trq_kind_e                    grant_kind,
  output logic [PAYLOAD_W-1:0]         grant_data
);
  // Lowest index wins: scan from the top so the lowest set bit is written last.
  always_comb begin
    grant_valid = |req;
    grant_kind  = KIND_DATA;
    grant_data  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant_kind = trq_kind_e'(i[KIND_W-1:0]);
        grant_data = req_data[i*PAYLOAD_W +: PAYLOAD_W];
      end
    end
  end
endmodule

// File: rtl/trq_fifo.sv
module trq_fifo #(
  parameter int WIDTH = 19,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign rd_data = mem[rd_ptr];

  // Storage without reset so it maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
endmodule

// File: rtl/trq_recovery.sv
module trq_recovery
  import trq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] offer,
  input  logic               fifo_full,
  input  logic               fifo_empty,
  output logic               accept_ok,
  output logic               insert_err,
  output logic [NUM_SRC-1:0] err_mask,
  output logic               sync_req
);
  logic               draining;
  logic [NUM_SRC-1:0] drop_mask;

  assign insert_err = draining && fifo_empty;
  assign err_mask   = drop_mask | offer;
  assign accept_ok  = !draining && !fifo_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      draining  <= 1'b0;
      drop_mask <= '0;
      sync_req  <= 1'b0;
    end else begin
      sync_req <= insert_err;
      if (insert_err) begin
        draining  <= 1'b0;
        drop_mask <= '0;
      end else if (draining) begin
        drop_mask <= drop_mask | offer;
      end else if (fifo_full && |offer) begin
        draining  <= 1'b1;
        drop_mask <= offer;
      end
    end
  end

  assert_sync_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    sync_req |=> !sync_req);
  assert_mask_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !draining |-> (drop_mask == '0));
  assert_drain_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (draining && !fifo_empty) |=> draining);
  assert_drain_entry_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(draining) |-> $past(fifo_full && (offer != '0)));
endmodule

// File: rtl/trq_top.sv
module trq_top
  import trq_pkg::*;
#(
  parameter int PAYLOAD_W = 16,
  parameter int DEPTH     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wp_valid,
  input  logic [PAYLOAD_W-1:0] wp_data,
  input  logic                 own_valid,
  input  logic [PAYLOAD_W-1:0] own_data,
  input  logic                 br_valid,
  input  logic [PAYLOAD_W-1:0] br_data,
  input  logic                 dt_valid,
  input  logic [PAYLOAD_W-1:0] dt_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [KIND_W-1:0]    out_kind,
  output logic [PAYLOAD_W-1:0] out_data,
  output logic                 sync_req
);
  localparam int ENTRY_W = KIND_W + PAYLOAD_W;
  localparam int PAD_W   = PAYLOAD_W - NUM_SRC;

  logic [NUM_SRC-1:0]           offer;
  logic [NUM_SRC*PAYLOAD_W-1:0] offer_data;
  logic                         grant_valid;
  trq_kind_e                    grant_kind;
  logic [PAYLOAD_W-1:0]         grant_data;
  logic                         accept_ok, insert_err;
  logic [NUM_SRC-1:0]           err_mask;
  logic                         fifo_full, fifo_empty;
  logic                         push, pop;
  logic [ENTRY_W-1:0]           push_entry, head_entry;

  assign offer      = {dt_valid, br_valid, own_valid, wp_valid};
  assign offer_data = {dt_data, br_data, own_data, wp_data};

  trq_arbiter #(.PAYLOAD_W(PAYLOAD_W)) u_arb (
    .req         (offer),
    .req_data    (offer_data),
    .grant_valid (grant_valid),
    .grant_kind  (grant_kind),
    .grant_data  (grant_data)
  );

  trq_recovery u_rec (
    .clk        (clk),
    .rst        (rst),
    .offer      (offer),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .accept_ok  (accept_ok),
    .insert_err (insert_err),
    .err_mask   (err_mask),
    .sync_req   (sync_req)
  );

  assign push       = insert_err || (grant_valid && accept_ok);
  assign push_entry = insert_err ? {KIND_ERR, {PAD_W{1'b0}}, err_mask}
                                 : {grant_kind, grant_data};
  assign pop        = out_valid && out_ready;

  trq_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push),
    .wr_data (push_entry),
    .rd_en   (pop),
    .rd_data (head_entry),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  assign out_valid = !fifo_empty;
  assign out_kind  = head_entry[ENTRY_W-1 -: KIND_W];
  assign out_data  = head_entry[PAYLOAD_W-1:0];

  assert_err_at_head_R8: assert property (@(posedge clk) disable iff (rst)
    sync_req |-> (out_valid && out_kind == KIND_ERR));
  assert_err_mask_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    sync_req |-> (out_data[NUM_SRC-1:0] != '0));
endmodule

// File: tb/trq_top_tb.sv
module trq_top_tb;
  localparam int PW    = 16;
  localparam int DEPTH = 8;
  localparam int EW    = 3 + PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_valid = 0, own_valid = 0, br_valid = 0, dt_valid = 0, out_ready = 0;
  logic [PW-1:0] wp_data = '0, own_data = '0, br_data = '0, dt_data = '0;
  logic out_valid, sync_req;
  logic [2:0] out_kind;
  logic [PW-1:0] out_data;

  always #10 clk = ~clk;

  trq_top #(.PAYLOAD_W(PW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst),
    .wp_valid(wp_valid), .wp_data(wp_data),
    .own_valid(own_valid), .own_data(own_data),
    .br_valid(br_valid), .br_data(br_data),
    .dt_valid(dt_valid), .dt_data(dt_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_data(out_data),
    .sync_req(sync_req)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [EW-1:0] mq [$];
  bit m_drain = 0;
  logic [3:0] m_mask = '0;
  bit exp_sync = 0;
  logic [15:0] seq = 16'd1;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check_outputs();
    vectors++;
    if (out_valid !== (mq.size() > 0)) begin
      miscompares++;
      $display("FAIL %s out_valid act=%0b exp=%0b", cur_req, out_valid, mq.size() > 0);
    end
    if (mq.size() > 0) begin
      vectors++;
      if ({out_kind, out_data} !== mq[0]) begin
        miscompares++;
        $display("FAIL %s head act=%h/%h exp=%h/%h", cur_req, out_kind, out_data,
                 mq[0][EW-1 -: 3], mq[0][PW-1:0]);
      end
    end
    vectors++;
    if (sync_req !== exp_sync) begin
      miscompares++;
      $display("FAIL R8 (%s) sync_req act=%0b exp=%0b", cur_req, sync_req, exp_sync);
    end
  endtask

  // Called just after a falling edge; result checked at the next falling edge.
  task automatic step(input logic [3:0] v, input logic rdy);
    logic [PW-1:0] d [4];
    int pre;
    for (int i = 0; i < 4; i++) d[i] = {seq[13:0], i[1:0]};
    {dt_valid, br_valid, own_valid, wp_valid} = v;
    wp_data = d[0]; own_data = d[1]; br_data = d[2]; dt_data = d[3];
    out_ready = rdy;
    pre = mq.size();
    if (rdy && pre > 0) void'(mq.pop_front());
    exp_sync = 0;
    if (m_drain) begin
      if (pre == 0) begin
        mq.push_back({3'd4, {(PW-4){1'b0}}, m_mask | v});
        m_drain = 0;
        m_mask = '0;
        exp_sync = 1;
      end else begin
        m_mask |= v;
      end
    end else if (v != 0) begin
      if (pre == DEPTH) begin
        m_drain = 1;
        m_mask = v;
      end else begin
        for (int i = 3; i >= 0; i--) begin
          if (v[i]) begin
            mq.push_front(mq.size() == 0 ? '0 : mq[0]);
            void'(mq.pop_front());
          end
        end
        begin
          int win = 0;
          for (int i = 3; i >= 0; i--) if (v[i]) win = i;
          mq.push_back({3'(win), d[win]});
        end
      end
    end
    seq++;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic drain_all();
    while (mq.size() > 0 || m_drain) step(4'b0000, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    check_outputs();
    rst = 1'b0;
    @(negedge clk);
    check_outputs();

    // R10: single message latency, alternating consumer
    cur_req = "R10";
    step(4'b0100, 1'b0);
    step(4'b0000, 1'b1);
    step(4'b1000, 1'b1);
    step(4'b0000, 1'b1);

    // R2: every combination of simultaneous offers
    cur_req = "R2";
    for (int m = 1; m < 16; m++) begin
      step(4'(m), 1'b0);
      step(4'b0000, 1'b1);
    end

    // R4: fill to DEPTH, then offer at full with a removal in the same cycle
    cur_req = "R4";
    for (int k = 0; k < DEPTH; k++) step(4'(1 << (k % 4)), 1'b0);
    step(4'b0100, 1'b1);

    // R5: drain while offering data messages; R7 offer at insertion cycle
    cur_req = "R5";
    while (m_drain) begin
      if (mq.size() == 0) begin
        cur_req = "R7";
        step(4'b0001, 1'b0);
      end else begin
        step(4'b1000, seq[0]);
      end
    end
    cur_req = "R6";
    step(4'b0000, 1'b0);
    vectors++;
    if (out_data !== 16'h000D || out_kind !== 3'd4) begin
      miscompares++;
      $display("FAIL R6 error record act=%h/%h exp=4/000d", out_kind, out_data);
    end
    step(4'b0000, 1'b1);

    // R9: second overrun reports only its own kinds
    cur_req = "R9";
    for (int k = 0; k < DEPTH; k++) step(4'b0010, 1'b0);
    step(4'b0010, 1'b0);
    while (m_drain) step(4'b0000, 1'b1);
    step(4'b0000, 1'b0);
    vectors++;
    if (out_data !== 16'h0002) begin
      miscompares++;
      $display("FAIL R9 error mask act=%h exp=0002", out_data);
    end
    drain_all();

    // R3: pseudo-random traffic
    cur_req = "R3";
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] & lfsr[7:4], lfsr[8] & lfsr[9]);
    end
    drain_all();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule